// File: doc/BRIEF.md
# Switch-on-Event Hardware Thread Controller

This block decides which hardware thread a small single-issue core runs. The core keeps executing one thread until that thread takes a long-latency memory miss. The controller then marks the thread as waiting, asks the pipeline to flush, and picks the next thread that can run. After the switch, it holds fetch off for a fixed refill interval. Each thread has its own register bank, so a switch only changes the bank select. No context is saved or restored.

Every thread is in one of three states: ready, running or blocked. A blocked thread returns to ready when the memory system pulses its completion line. If all threads are blocked, the controller idles with fetch off. It resumes as soon as any completion arrives. For each thread, a counter records how many cycles its most recent blocking lasted. A sticky flag catches completions that arrive for a thread that was not waiting.

Top module: `soe_thread_ctrl`

## Requirements
- R1: After reset, thread 0 is running, `activeTid` is 0, `bankSel` is one-hot with bit 0 set, `fetchEn` is 1, `flushReq` is 0, `errSticky` is 0 and every blocked-cycle counter is 0.
- R2: A miss sampled while `fetchEn` is 1 and `missTid` equals `activeTid` blocks that thread. On the next cycle `fetchEn` is 0 and `flushReq` is 1.
- R3: `flushReq` stays 1 and `activeTid` holds until `pipeDrained` is sampled high. At that edge, if a thread is ready, `activeTid` takes the chosen thread, `bankSel` is its one-hot code (bit i set for thread i), and `flushReq` falls.
- R4: `fetchEn` becomes 1 exactly `FILL_CYCLES` clock edges after the edge that switched `activeTid`, and it stays 0 until then.
- R5: The next thread is the first ready thread found by searching upward from the blocked thread's ID plus one, wrapping from N-1 to 0 and skipping blocked threads.
- R6: If no thread is ready when the pipeline drains, `fetchEn` and `flushReq` both stay 0 and `activeTid` holds. On the edge after a completion makes a thread ready, that thread is chosen from the held `activeTid` plus one, and the refill interval of R4 follows.
- R7: A miss is ignored when `missTid` differs from `activeTid`, or when `fetchEn` is 0 (during a refill).
- R8: A completion pulse on `doneVec[i]` for a blocked thread i makes it ready. A completion for a thread that is not blocked sets `errSticky`, which stays 1 until reset and leaves the thread selection unchanged.
- R9: A thread's field in `blockCnt` (bits i*CNT_W upward) is cleared when the thread blocks and grows by one on each edge that finds it blocked. It therefore equals K when the completion is sampled K edges after the miss, and it holds that value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Long-latency miss event pulse |
| missTid | input | TW | Thread that missed |
| doneVec | input | N | Per-thread memory completion pulses |
| pipeDrained | input | 1 | Pipeline has emptied after a flush |
| activeTid | output | TW | Thread currently selected |
| bankSel | output | N | One-hot register bank select |
| flushReq | output | 1 | Request to flush the pipeline |
| fetchEn | output | 1 | Fetch may proceed for `activeTid` |
| errSticky | output | 1 | Completion seen for a non-blocked thread |
| blockCnt | output | N*CNT_W | Per-thread cycles spent in the last blocking |

## Verification
The bench targets wrap-around and skipping in the round-robin search. A wrong search start would pick the blocked thread itself or a lower-numbered thread. It also counts the exact refill length edge by edge, where an off-by-one in the fill counter would open fetch one cycle early or late. The all-blocked idle case checks that the controller resumes on the first completion, and a design that relaunched blindly would turn fetch on with nothing to run. Stray misses during refill and for other threads, plus completions for the running thread, catch a design that switches spuriously or forgets the error.

// File: rtl/soe_pkg.sv
package soe_pkg;

  typedef enum logic [1:0] {
    TS_READY   = 2'd0,
    TS_RUNNING = 2'd1,
    TS_BLOCKED = 2'd2
  } thr_state_e;

  typedef enum logic [1:0] {
    CS_RUN   = 2'd0,
    CS_FLUSH = 2'd1,
    CS_FILL  = 2'd2,
    CS_IDLE  = 2'd3
  } ctl_state_e;

  // strobes from the switch control to the thread datapath
  typedef struct packed {
    logic blockRun;  // running thread takes a miss
    logic launch;    // picked thread becomes running
  } ctl_strobe_t;

endpackage

// File: rtl/soe_rr_pick.sv
module soe_rr_pick #(
  parameter int N  = 4,
  parameter int TW = $clog2(N)
) (
  input  logic [TW-1:0] baseTid,
  input  logic [N-1:0]  readyVec,
  output logic          found,
  output logic [TW-1:0] pickTid
);

  // search base+1, base+2, ... wrapping, base itself last
  always_comb begin
    found   = 1'b0;
    pickTid = baseTid;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(baseTid) + k) % N;
      if (!found && readyVec[idx]) begin
        found   = 1'b1;
        pickTid = TW'(idx);
      end
    end
  end

endmodule

// File: rtl/soe_switch_ctrl.sv
module soe_switch_ctrl
  import soe_pkg::*;
#(
  parameter int N           = 4,
  parameter int TW          = $clog2(N),
  parameter int FILL_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          missValid,
  input  logic [TW-1:0] missTid,
  input  logic          pipeDrained,
  input  logic          found,
  input  logic [TW-1:0] pickTid,
  output ctl_strobe_t   strobe,
  output logic [TW-1:0] activeTid,
  output logic          fetchEn,
  output logic          flushReq
);

  localparam int FW = (FILL_CYCLES < 2) ? 1 : $clog2(FILL_CYCLES);
  localparam logic [FW-1:0] FILL_LOAD = FW'(FILL_CYCLES - 1);

  ctl_state_e ctlState;
  logic [FW-1:0] fillCnt;
  logic missHit;
  logic launchNow;

  assign missHit   = missValid && (missTid == activeTid) && (ctlState == CS_RUN);
  assign launchNow = found && (((ctlState == CS_FLUSH) && pipeDrained) ||
                               (ctlState == CS_IDLE));

  assign strobe.blockRun = missHit;
  assign strobe.launch   = launchNow;

  assign fetchEn  = (ctlState == CS_RUN);
  assign flushReq = (ctlState == CS_FLUSH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctlState  <= CS_RUN;
      activeTid <= '0;
      fillCnt   <= '0;
    end else begin
      unique case (ctlState)
        CS_RUN: begin
          if (missHit) ctlState <= CS_FLUSH;
        end
        CS_FLUSH: begin
          if (pipeDrained) begin
            if (found) begin
              activeTid <= pickTid;
              fillCnt   <= FILL_LOAD;
              ctlState  <= CS_FILL;
            end else begin
              ctlState  <= CS_IDLE;
            end
          end
        end
        CS_FILL: begin
          if (fillCnt == '0) ctlState <= CS_RUN;
          else               fillCnt  <= fillCnt - 1'b1;
        end
        CS_IDLE: begin
          if (found) begin
            activeTid <= pickTid;
            fillCnt   <= FILL_LOAD;
            ctlState  <= CS_FILL;
          end
        end
        default: ctlState <= CS_RUN;
      endcase
    end
  end

  // R2: accepted miss turns fetch off and raises the flush request
  a_r2_miss_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchEn && missValid && missTid == activeTid) |=> (flushReq && !fetchEn));

  // R3: flush request and thread hold until the drain indication
  a_r3_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flushReq && !pipeDrained) |=> (flushReq && $stable(activeTid)));

  // R6: idle with nothing ready keeps fetch off
  a_r6_idle_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetchEn && !flushReq && ctlState == CS_IDLE && !found) |=> !fetchEn);

  // R7: a miss for another thread while fetching changes nothing
  a_r7_stray_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchEn && missValid && missTid != activeTid) |=> (fetchEn && $stable(activeTid)));

endmodule

// File: rtl/soe_thread_dp.sv
module soe_thread_dp
  import soe_pkg::*;
#(
  parameter int N     = 4,
  parameter int TW    = $clog2(N),
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_strobe_t      strobe,
  input  logic [TW-1:0]    activeTid,
  input  logic [TW-1:0]    pickTid,
  input  logic [N-1:0]     doneVec,
  output logic [N-1:0]     readyVec,
  output logic [N-1:0]     runVec,
  output logic             errSticky,
  output logic [N*CNT_W-1:0] blockCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  thr_state_e       stArr  [N];
  logic [CNT_W-1:0] cntArr [N];
  logic [N-1:0]     errHit;
  logic [N-1:0]     blkVec;

  for (genvar i = 0; i < N; i++) begin : g_thr
    logic blkHit;
    logic launchHit;

    assign blkHit    = strobe.blockRun && (activeTid == TW'(i));
    assign launchHit = strobe.launch && (pickTid == TW'(i));

    assign readyVec[i] = (stArr[i] == TS_READY);
    assign runVec[i]   = (stArr[i] == TS_RUNNING);
    assign blkVec[i]   = (stArr[i] == TS_BLOCKED);
    assign errHit[i]   = doneVec[i] && !blkVec[i];
    assign blockCnt[i*CNT_W +: CNT_W] = cntArr[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stArr[i]  <= (i == 0) ? TS_RUNNING : TS_READY;
        cntArr[i] <= '0;
      end else if (blkHit) begin
        stArr[i]  <= TS_BLOCKED;
        cntArr[i] <= '0;
      end else begin
        if (blkVec[i] && cntArr[i] != CNT_MAX) cntArr[i] <= cntArr[i] + 1'b1;
        if (launchHit)                   stArr[i] <= TS_RUNNING;
        else if (doneVec[i] && blkVec[i]) stArr[i] <= TS_READY;
      end
    end

    // R8: completion releases a blocked thread
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      (doneVec[i] && blkVec[i]) |=> readyVec[i]);

    // R9: blocked-cycle counter advances while still blocked
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (blkVec[i] && $past(blkVec[i]) && $past(cntArr[i]) != CNT_MAX)
        |-> (cntArr[i] == $past(cntArr[i]) + 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) errSticky <= 1'b0;
    else        errSticky <= errSticky | (|errHit);
  end

  // R8: the error flag never clears on its own
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    errSticky |=> errSticky);

  // R1: never more than one running thread
  a_r1_single_run: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(runVec) <= 1);

endmodule

// File: rtl/soe_thread_ctrl.sv
module soe_thread_ctrl
  import soe_pkg::*;
#(
  parameter int N           = 4,
  parameter int FILL_CYCLES = 3,
  parameter int CNT_W       = 16,
  localparam int TW         = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               missValid,
  input  logic [TW-1:0]      missTid,
  input  logic [N-1:0]       doneVec,
  input  logic               pipeDrained,
  output logic [TW-1:0]      activeTid,
  output logic [N-1:0]       bankSel,
  output logic               flushReq,
  output logic               fetchEn,
  output logic               errSticky,
  output logic [N*CNT_W-1:0] blockCnt
);

  ctl_strobe_t   strobe;
  logic [N-1:0]  readyVec;
  logic [N-1:0]  runVec;
  logic          found;
  logic [TW-1:0] pickTid;

  soe_rr_pick #(.N(N), .TW(TW)) pick_i (
    .baseTid (activeTid),
    .readyVec(readyVec),
    .found   (found),
    .pickTid (pickTid)
  );

  soe_switch_ctrl #(.N(N), .TW(TW), .FILL_CYCLES(FILL_CYCLES)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .missValid  (missValid),
    .missTid    (missTid),
    .pipeDrained(pipeDrained),
    .found      (found),
    .pickTid    (pickTid),
    .strobe     (strobe),
    .activeTid  (activeTid),
    .fetchEn    (fetchEn),
    .flushReq   (flushReq)
  );

  soe_thread_dp #(.N(N), .TW(TW), .CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .activeTid(activeTid),
    .pickTid  (pickTid),
    .doneVec  (doneVec),
    .readyVec (readyVec),
    .runVec   (runVec),
    .errSticky(errSticky),
    .blockCnt (blockCnt)
  );

  for (genvar i = 0; i < N; i++) begin : g_bank
    assign bankSel[i] = (activeTid == TW'(i));
  end

  // R1/R3: while fetching, the selected thread is the running one
  a_r1_active_running: assert property (@(posedge clk) disable iff (!rst_n)
    fetchEn |-> runVec[activeTid]);

endmodule

// File: tb/soe_thread_ctrl_tb_top.sv
module soe_thread_ctrl_tb_top;

  localparam int N  = 4;
  localparam int F  = 3;
  localparam int CW = 16;
  localparam int TW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic missValid = 1'b0;
  logic [TW-1:0] missTid = '0;
  logic [N-1:0] doneVec = '0;
  logic pipeDrained = 1'b0;
  logic [TW-1:0] activeTid;
  logic [N-1:0] bankSel;
  logic flushReq, fetchEn, errSticky;
  logic [N*CW-1:0] blockCnt;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  soe_thread_ctrl #(.N(N), .FILL_CYCLES(F), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .missValid(missValid), .missTid(missTid),
    .doneVec(doneVec), .pipeDrained(pipeDrained), .activeTid(activeTid),
    .bankSel(bankSel), .flushReq(flushReq), .fetchEn(fetchEn),
    .errSticky(errSticky), .blockCnt(blockCnt)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int cntOf(input int t);
    return int'(blockCnt[t*CW +: CW]);
  endfunction

  task automatic pulseMiss(input int t);
    missValid = 1'b1; missTid = TW'(t);
    tick();
    missValid = 1'b0;
  endtask

  task automatic pulseDone(input int t);
    doneVec = N'(1) << t;
    tick();
    doneVec = '0;
  endtask

  task automatic drain();
    pipeDrained = 1'b1;
    tick();
    pipeDrained = 1'b0;
  endtask

  // called just after the switching edge
  task automatic expectFill(input string req);
    chk(int'(fetchEn), 0, req, "fetch off at switch");
    for (int k = 1; k < F; k++) begin
      tick();
      chk(int'(fetchEn), 0, req, "fetch off during refill");
    end
    tick();
    chk(int'(fetchEn), 1, req, "fetch on after refill");
  endtask

  task automatic switchTo(input int from, input int expNext, input string req);
    pulseMiss(from);
    chk(int'(flushReq), 1, "R2", "flush after miss");
    chk(int'(fetchEn), 0, "R2", "fetch off after miss");
    drain();
    chk(int'(activeTid), expNext, req, "next thread");
    chk(int'(bankSel), 1 << expNext, "R3", "bank one-hot");
    chk(int'(flushReq), 0, "R3", "flush drops at switch");
    expectFill("R4");
  endtask

  task automatic t_reset();
    chk(int'(activeTid), 0, "R1", "active after reset");
    chk(int'(bankSel), 1, "R1", "bank after reset");
    chk(int'(fetchEn), 1, "R1", "fetch after reset");
    chk(int'(flushReq), 0, "R1", "flush after reset");
    chk(int'(errSticky), 0, "R1", "err after reset");
    for (int t = 0; t < N; t++) chk(cntOf(t), 0, "R1", "counter after reset");
  endtask

  task automatic t_stray_miss();
    pulseMiss(2);
    chk(int'(fetchEn), 1, "R7", "fetch kept on other-thread miss");
    chk(int'(flushReq), 0, "R7", "no flush on other-thread miss");
    chk(int'(activeTid), 0, "R7", "active kept");
  endtask

  task automatic t_first_switch();
    pulseMiss(0);
    chk(int'(flushReq), 1, "R2", "flush after miss");
    chk(int'(fetchEn), 0, "R2", "fetch off after miss");
    repeat (3) begin
      tick();
      chk(int'(flushReq), 1, "R3", "flush held without drain");
      chk(int'(activeTid), 0, "R3", "active held without drain");
    end
    drain();
    chk(int'(activeTid), 1, "R5", "first switch to thread 1");
    chk(int'(bankSel), 2, "R3", "bank one-hot thread 1");
    chk(int'(flushReq), 0, "R3", "flush drops");
    chk(int'(fetchEn), 0, "R4", "fetch off at switch");
    pulseMiss(1);  // sampled during refill: ignored
    chk(int'(fetchEn), 0, "R4", "refill cycle 1");
    tick();
    chk(int'(fetchEn), 0, "R4", "refill cycle 2");
    tick();
    chk(int'(fetchEn), 1, "R4", "fetch on after refill");
    chk(int'(flushReq), 0, "R7", "refill miss ignored, no flush");
    chk(int'(activeTid), 1, "R7", "refill miss ignored, active kept");
  endtask

  task automatic t_counter();
    pulseDone(0);
    chk(int'(errSticky), 0, "R8", "legal completion no error");
    pulseMiss(1);
    repeat (6) tick();
    pulseDone(1);
    chk(cntOf(1), 7, "R9", "blocked cycles");
    repeat (3) tick();
    chk(cntOf(1), 7, "R9", "counter holds");
    drain();
    chk(int'(activeTid), 2, "R5", "switch to thread 2");
    expectFill("R4");
  endtask

  task automatic t_round_robin();
    switchTo(2, 3, "R5");
    switchTo(3, 0, "R5");        // wrap
    pulseDone(3);
    chk(int'(errSticky), 0, "R8", "legal completion no error");
    switchTo(0, 1, "R5");
    switchTo(1, 3, "R5");        // skips blocked thread 2
  endtask

  task automatic t_all_blocked();
    pulseMiss(3);
    drain();
    chk(int'(fetchEn), 0, "R6", "fetch off when all blocked");
    chk(int'(flushReq), 0, "R6", "flush off when all blocked");
    chk(int'(activeTid), 3, "R6", "active held when all blocked");
    repeat (4) tick();
    chk(int'(fetchEn), 0, "R6", "still idle");
    chk(int'(flushReq), 0, "R6", "still no flush");
    pulseDone(1);
    chk(int'(activeTid), 3, "R6", "no launch at completion edge");
    chk(int'(fetchEn), 0, "R6", "fetch off at completion edge");
    tick();
    chk(int'(activeTid), 1, "R6", "resume with completed thread");
    expectFill("R6");
  endtask

  task automatic t_error();
    chk(int'(errSticky), 0, "R8", "no error before bad completion");
    pulseDone(1);
    chk(int'(errSticky), 1, "R8", "error on running-thread completion");
    chk(int'(activeTid), 1, "R8", "active unchanged by bad completion");
    chk(int'(fetchEn), 1, "R8", "fetch unchanged by bad completion");
    repeat (3) tick();
    chk(int'(errSticky), 1, "R8", "error sticky");
  endtask

  task automatic t_rereset();
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    t_reset();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    t_reset();
    t_stray_miss();
    t_first_switch();
    t_counter();
    t_round_robin();
    t_all_blocked();
    t_error();
    t_rereset();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule